// File: doc/BRIEF.md
# Pixel Shift-Expand-Add Pipeline

This block is a three-stage streaming datapath for 32-bit pixel words. Every accepted pixel is first shifted by a signed amount with zero fill. It can then be replaced by one of two programmed colours, chosen by its lowest bit. Finally, a signed constant is added to its low 24-bit field with saturation. A per-pixel direction flag travels with each word. It states whether the pixel belongs to a read transfer, and a read transfer reverses the meaning of the shift sign.

Pixels move through a valid/ready stream, one pixel per cycle when the consumer is ready. Each operation has its own pipeline register, so the latency is three cycles. A simple register write port sets the shift amount, the expand enable, the two colours and the addend. An illegal shift amount written to that port is refused, and the port reports it with a one-cycle error pulse. The configuration should only be changed while the pipeline is empty, because the later stages read the live register values.

Top module: `pix_sea_pipe`

## Requirements
- R1: After reset `out_valid` and `cfg_err` are 0 and `in_ready` is 1. All configuration values are zero, and in that state every pixel leaves the block unchanged.
- R2: The operations are always applied in the order shift, then expand, then add, for both read and write pixels.
- R3: For a pixel with `in_rd`=0, a positive shift amount moves the bits left and a negative amount moves them right.
- R4: For a pixel with `in_rd`=1, the direction is reversed: a positive amount moves the bits right and a negative amount moves them left.
- R5: Bit positions vacated by a shift are filled with zeros.
- R6: A write with `cfg_sel`=0 sets the shift amount, taken as the signed 32-bit `cfg_wdata`. Only 0, ±1, ±4, ±8, ±12, ±16 and ±24 are accepted. Any other value leaves the shift amount unchanged and drives `cfg_err` high for exactly the next cycle. No other write raises `cfg_err`.
- R7: When expansion is enabled (`cfg_sel`=1, `cfg_wdata[0]`=1), bit 0 of the shifted pixel selects the whole output word: 0 gives colour 0 (`cfg_sel`=2) and 1 gives colour 1 (`cfg_sel`=3).
- R8: When expansion is disabled (`cfg_wdata[0]`=0 at `cfg_sel`=1), the shifted pixel passes through, whatever the colours hold.
- R9: The add stage treats pixel bits 23:0 as a signed value. It adds the signed addend held in `cfg_wdata[23:0]` of a `cfg_sel`=4 write, and passes bits 31:24 through unchanged.
- R10: The add result saturates at 0x7FFFFF and at 0x800000 instead of wrapping.
- R11: With `out_ready` held high, `in_ready` stays high, pixels are accepted every cycle, and each one appears on the output three cycles after it is accepted.
- R12: Under any pattern of `out_ready`, every accepted pixel leaves exactly once and in order. A stalled output holds its valid and data unchanged until it is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 shift, 1 expand enable, 2 colour 0, 3 colour 1, 4 addend |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_err | output | 1 | One-cycle pulse after an illegal shift write |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept an input pixel |
| in_data | input | 32 | Input pixel |
| in_rd | input | 1 | Pixel belongs to a read transfer (reverses shift sign) |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts the output pixel |
| out_data | output | 32 | Processed pixel |

## Verification
The bound checker watches the stream and register behaviour on every cycle. It checks that a stalled output holds its value and that occupancy never exceeds three pixels or produces output from an empty pipe. It also checks that the stored shift amount is always legal, that an error pulse follows only a shift write, and that ready propagates back when the consumer is ready. It also confirms that the top byte survives the add stage. The arithmetic itself needs the bench's sweeps to be shown correct: the shift direction for each legal amount and transfer kind, zero fill, colour selection after shifting, the order of operations, and saturation at both ends.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

   // Configuration register select codes
   typedef enum logic [2:0] {
      SEL_SHIFT  = 3'd0,
      SEL_EXPAND = 3'd1,
      SEL_COLOR0 = 3'd2,
      SEL_COLOR1 = 3'd3,
      SEL_ADDEND = 3'd4
   } cfg_sel_e;

   // True when a shift magnitude is one of the accepted step sizes
   function automatic logic shift_mag_ok(input logic [63:0] mag);
      case (mag)
         64'd0, 64'd1, 64'd4, 64'd8, 64'd12, 64'd16, 64'd24: return 1'b1;
         default:                                            return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/pxs_cfg_regs.sv
module pxs_cfg_regs
   import pxs_pkg::*;
#(
   parameter int PIX_W   = 32,
   parameter int ADD_W   = 24,
   parameter int SHIFT_W = 6
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [2:0]                cfg_sel,
   input  logic [PIX_W-1:0]          cfg_wdata,
   output logic signed [SHIFT_W-1:0] sh_amt,
   output logic                      exp_en,
   output logic [PIX_W-1:0]          col0,
   output logic [PIX_W-1:0]          col1,
   output logic [ADD_W-1:0]          addend,
   output logic                      err
);

   logic [PIX_W-1:0] wmag;
   logic             legal;

   assign wmag  = cfg_wdata[PIX_W-1] ? (~cfg_wdata + PIX_W'(1)) : cfg_wdata;
   assign legal = shift_mag_ok(64'(wmag));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_amt <= '0;
         exp_en <= 1'b0;
         col0   <= '0;
         col1   <= '0;
         addend <= '0;
         err    <= 1'b0;
      end else begin
         err <= 1'b0;
         if (cfg_we) begin
            case (cfg_sel)
               SEL_SHIFT: begin
                  if (legal) sh_amt <= cfg_wdata[SHIFT_W-1:0];
                  else       err    <= 1'b1;
               end
               SEL_EXPAND: exp_en <= cfg_wdata[0];
               SEL_COLOR0: col0   <= cfg_wdata;
               SEL_COLOR1: col1   <= cfg_wdata;
               SEL_ADDEND: addend <= cfg_wdata[ADD_W-1:0];
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/pxs_pipe_reg.sv
module pxs_pipe_reg #(
   parameter int W = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         up_valid,
   output logic         up_ready,
   input  logic [W-1:0] up_data,
   output logic         dn_valid,
   input  logic         dn_ready,
   output logic [W-1:0] dn_data
);

   // Register loads whenever it is empty or its content is being taken
   assign up_ready = !dn_valid || dn_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dn_valid <= 1'b0;
         dn_data  <= '0;
      end else if (up_ready) begin
         dn_valid <= up_valid;
         if (up_valid) dn_data <= up_data;
      end
   end

endmodule

// File: rtl/pxs_shifter.sv
module pxs_shifter #(
   parameter int PIX_W   = 32,
   parameter int SHIFT_W = 6,
   parameter int IMPL    = 0   // 0: general barrel, 1: mux of legal steps only
)(
   input  logic [PIX_W-1:0]          din,
   input  logic signed [SHIFT_W-1:0] amt,
   input  logic                      rd,
   output logic [PIX_W-1:0]          dout
);

   logic [SHIFT_W-1:0] mag;
   logic               go_left;

   assign mag     = amt[SHIFT_W-1] ? $unsigned(-amt) : $unsigned(amt);
   // Positive means left on write; a read flips the sense
   assign go_left = (!amt[SHIFT_W-1]) ^ rd;

   if (IMPL == 0) begin : g_barrel
      assign dout = go_left ? (din << mag) : (din >> mag);
   end else begin : g_stepmux
      always_comb begin
         case (mag)
            SHIFT_W'(1):  dout = go_left ? (din << 1)  : (din >> 1);
            SHIFT_W'(4):  dout = go_left ? (din << 4)  : (din >> 4);
            SHIFT_W'(8):  dout = go_left ? (din << 8)  : (din >> 8);
            SHIFT_W'(12): dout = go_left ? (din << 12) : (din >> 12);
            SHIFT_W'(16): dout = go_left ? (din << 16) : (din >> 16);
            SHIFT_W'(24): dout = go_left ? (din << 24) : (din >> 24);
            default:      dout = din;
         endcase
      end
   end

endmodule

// File: rtl/pxs_sat_add.sv
module pxs_sat_add #(
   parameter int PIX_W = 32,
   parameter int ADD_W = 24
)(
   input  logic [PIX_W-1:0] din,
   input  logic [ADD_W-1:0] addend,
   output logic [PIX_W-1:0] dout
);

   localparam logic [ADD_W-1:0] FIELD_MAX = {1'b0, {(ADD_W-1){1'b1}}};
   localparam logic [ADD_W-1:0] FIELD_MIN = {1'b1, {(ADD_W-1){1'b0}}};

   logic [ADD_W:0]   sum;
   logic [ADD_W-1:0] field;

   // Sign-extend both operands by one bit; the extra bit exposes overflow
   assign sum = {din[ADD_W-1], din[ADD_W-1:0]} + {addend[ADD_W-1], addend};

   always_comb begin
      if (sum[ADD_W] != sum[ADD_W-1]) field = sum[ADD_W] ? FIELD_MIN : FIELD_MAX;
      else                            field = sum[ADD_W-1:0];
   end

   assign dout = {din[PIX_W-1:ADD_W], field};

endmodule

// File: rtl/pix_sea_pipe.sv
module pix_sea_pipe
   import pxs_pkg::*;
#(
   parameter int PIX_W      = 32,
   parameter int ADD_W      = 24,
   parameter int SHIFT_W    = 6,
   parameter int SHIFT_IMPL = 0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [PIX_W-1:0] cfg_wdata,
   output logic             cfg_err,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [PIX_W-1:0] in_data,
   input  logic             in_rd,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [PIX_W-1:0] out_data
);

   localparam int NSTG       = 3;
   localparam int STG_SHIFT  = 0;
   localparam int STG_EXPAND = 1;
   localparam int STG_ADD    = 2;

   // Elaboration-time parameter checks
   if (PIX_W < 25) begin : g_bad_pix
      $error("PIX_W must exceed the largest shift step of 24");
   end
   if (ADD_W < 2 || ADD_W >= PIX_W) begin : g_bad_add
      $error("ADD_W must lie between 2 and PIX_W-1");
   end
   if (SHIFT_W < 6) begin : g_bad_sh
      $error("SHIFT_W must hold signed amounts up to 24");
   end
   if (SHIFT_IMPL != 0 && SHIFT_IMPL != 1) begin : g_bad_impl
      $error("SHIFT_IMPL selects 0 or 1");
   end

   logic signed [SHIFT_W-1:0] sh_amt;
   logic                      exp_en;
   logic [PIX_W-1:0]          col0, col1;
   logic [ADD_W-1:0]          addend;

   pxs_cfg_regs #(.PIX_W(PIX_W), .ADD_W(ADD_W), .SHIFT_W(SHIFT_W)) cfg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .sh_amt    (sh_amt),
      .exp_en    (exp_en),
      .col0      (col0),
      .col1      (col1),
      .addend    (addend),
      .err       (cfg_err)
   );

   logic [PIX_W-1:0] st_in  [NSTG];
   logic [PIX_W-1:0] st_out [NSTG];
   logic             vld    [NSTG+1];
   logic             rdy    [NSTG+1];

   assign vld[0]    = in_valid;
   assign in_ready  = rdy[0];
   assign rdy[NSTG] = out_ready;
   assign out_valid = vld[NSTG];
   assign out_data  = st_out[STG_ADD];

   // Stage operations
   pxs_shifter #(.PIX_W(PIX_W), .SHIFT_W(SHIFT_W), .IMPL(SHIFT_IMPL)) shf_i (
      .din  (in_data),
      .amt  (sh_amt),
      .rd   (in_rd),
      .dout (st_in[STG_SHIFT])
   );

   assign st_in[STG_EXPAND] = exp_en ? (st_out[STG_SHIFT][0] ? col1 : col0)
                                     : st_out[STG_SHIFT];

   pxs_sat_add #(.PIX_W(PIX_W), .ADD_W(ADD_W)) add_i (
      .din    (st_out[STG_EXPAND]),
      .addend (addend),
      .dout   (st_in[STG_ADD])
   );

   // One register per operation
   for (genvar g = 0; g < NSTG; g++) begin : g_stage
      pxs_pipe_reg #(.W(PIX_W)) reg_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .up_valid (vld[g]),
         .up_ready (rdy[g]),
         .up_data  (st_in[g]),
         .dn_valid (vld[g+1]),
         .dn_ready (rdy[g+1]),
         .dn_data  (st_out[g])
      );
   end

   // Named taps for the bound checker
   logic             mid_valid;
   logic             mid_ready;
   logic [PIX_W-1:0] mid_pix;
   assign mid_valid = vld[STG_ADD];
   assign mid_ready = rdy[STG_ADD];
   assign mid_pix   = st_out[STG_EXPAND];

endmodule

// File: rtl/pix_sea_pipe_chk.sv
module pix_sea_pipe_chk #(
   parameter int PIX_W   = 32,
   parameter int ADD_W   = 24,
   parameter int SHIFT_W = 6,
   parameter int NSTG    = 3
)(
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cfg_we,
   input logic [2:0]                cfg_sel,
   input logic                      cfg_err,
   input logic                      in_valid,
   input logic                      in_ready,
   input logic                      out_valid,
   input logic                      out_ready,
   input logic [PIX_W-1:0]          out_data,
   input logic                      mid_valid,
   input logic                      mid_ready,
   input logic [PIX_W-1:0]          mid_data,
   input logic signed [SHIFT_W-1:0] sh_amt
);

   logic [7:0]         occ;
   logic [SHIFT_W-1:0] amag;
   logic               amt_ok;

   assign amag   = sh_amt[SHIFT_W-1] ? $unsigned(-sh_amt) : $unsigned(sh_amt);
   assign amt_ok = (amag == SHIFT_W'(0))  || (amag == SHIFT_W'(1))  ||
                   (amag == SHIFT_W'(4))  || (amag == SHIFT_W'(8))  ||
                   (amag == SHIFT_W'(12)) || (amag == SHIFT_W'(16)) ||
                   (amag == SHIFT_W'(24));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else if ((in_valid && in_ready) && !(out_valid && out_ready)) occ <= occ + 8'd1;
      else if (!(in_valid && in_ready) && (out_valid && out_ready)) occ <= occ - 8'd1;
   end

   // R6
   err_after_shift_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> ($past(cfg_we) && ($past(cfg_sel) == 3'd0)));

   // R6
   shift_amount_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      amt_ok);

   // R12
   stalled_output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R12
   occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= 8'(NSTG));

   // R12
   no_phantom_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (occ != 8'd0));

   // R11
   ready_backflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |-> in_ready);

   // R9
   top_byte_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_valid && mid_ready) |=> (out_data[PIX_W-1:ADD_W] == $past(mid_data[PIX_W-1:ADD_W])));

endmodule

bind pix_sea_pipe pix_sea_pipe_chk #(
   .PIX_W(PIX_W), .ADD_W(ADD_W), .SHIFT_W(SHIFT_W), .NSTG(NSTG)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_sel   (cfg_sel),
   .cfg_err   (cfg_err),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .mid_valid (mid_valid),
   .mid_ready (mid_ready),
   .mid_data  (mid_pix),
   .sh_amt    (sh_amt)
);

// File: tb/pix_sea_pipe_tb_top.sv
`timescale 1ns/1ps
module pix_sea_pipe_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = 3'd0;
   logic [31:0] cfg_wdata = '0;
   logic        cfg_err;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        in_rd = 1'b0;
   logic        out_valid;
   logic        out_ready;
   logic [31:0] out_data;

   always #2.5 clk = ~clk;   // 200 MHz

   pix_sea_pipe dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_rd(in_rd),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   int          n_chk = 0;
   int          n_err = 0;
   int          n_in = 0;
   int          n_out = 0;
   int          in_stalls = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   // Bench-side model of configuration
   int          m_sh = 0;
   bit          m_en = 1'b0;
   logic [31:0] m_c0 = '0;
   logic [31:0] m_c1 = '0;
   int          m_k = 0;

   bit          stall_mode = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   bit          done = 1'b0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic bit legal_shift(input int v);
      int a;
      a = (v < 0) ? -v : v;
      return (a == 0) || (a == 1) || (a == 4) || (a == 8) || (a == 12) || (a == 16) || (a == 24);
   endfunction

   function automatic logic [31:0] model(input logic [31:0] x, input bit rd);
      int          mag;
      bit          left;
      logic [31:0] s;
      logic [31:0] e;
      int          lo;
      int          sum;
      mag  = (m_sh < 0) ? -m_sh : m_sh;
      left = (m_sh > 0) ^ rd;
      s    = left ? (x << mag) : (x >> mag);
      e    = m_en ? (s[0] ? m_c1 : m_c0) : s;
      lo   = $signed(e[23:0]);
      sum  = lo + m_k;
      if (sum > 8388607)  sum = 8388607;
      if (sum < -8388608) sum = -8388608;
      return {e[31:24], sum[23:0]};
   endfunction

   // Output consumer: ready changes just after each rising edge
   initial begin
      out_ready = 1'b1;
      forever begin
         @(posedge clk);
         #1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         out_ready = stall_mode ? lfsr[0] : 1'b1;
      end
   end

   // Output monitor, sampled at the falling edge
   logic        prev_hold = 1'b0;
   logic [31:0] prev_data = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_hold) begin
            check("R12", {31'b0, out_valid}, 32'd1);
            check("R12", out_data, prev_data);
         end
         prev_hold = out_valid && !out_ready;
         prev_data = out_data;
         if (out_valid && out_ready) begin
            n_out++;
            if (exp_q.size() == 0) begin
               n_chk++;
               n_err++;
               $display("FAIL R12 actual output %h expected none", out_data);
            end else begin
               check(tag_q.pop_front(), out_data, exp_q.pop_front());
            end
         end
      end
   end

   // All driver tasks start and end 1 ns after a rising edge
   task automatic send(input logic [31:0] px, input bit rd, input string tag);
      in_valid = 1'b1;
      in_data  = px;
      in_rd    = rd;
      @(negedge clk);
      while (!in_ready) begin
         in_stalls++;
         @(negedge clk);
      end
      exp_q.push_back(model(px, rd));
      tag_q.push_back(tag);
      n_in++;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
      bit ill;
      ill = (sel == 3'd0) && !legal_shift($signed(data));
      drain();
      cfg_we    = 1'b1;
      cfg_sel   = sel;
      cfg_wdata = data;
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
      @(negedge clk);
      check("R6", {31'b0, cfg_err}, {31'b0, ill});
      @(negedge clk);
      check("R6", {31'b0, cfg_err}, 32'd0);
      @(posedge clk);
      #1;
      case (sel)
         3'd0: if (!ill) m_sh = $signed(data);
         3'd1: m_en = data[0];
         3'd2: m_c0 = data;
         3'd3: m_c1 = data;
         3'd4: m_k  = $signed(data[23:0]);
         default: ;
      endcase
   endtask

   int          shs[13] = '{0, 1, -1, 4, -4, 8, -8, 12, -12, 16, -16, 24, -24};
   logic [31:0] pats[4] = '{32'hFFFFFFFF, 32'h80000001, 32'h12345678, 32'hA5A5A5A5};
   int          bad[7]  = '{3, -5, 25, -25, 2, 100, 32'sh80000000};
   logic [31:0] xpats[6] = '{32'h0, 32'h1, 32'h2, 32'h3, 32'hFFFFFFFE, 32'hFFFFFFFF};
   logic [31:0] ks[6]   = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h007FFFFF, 32'hFF800000, 32'h00123456};
   logic [31:0] apx[5]  = '{32'h00000000, 32'hFF7FFFFF, 32'hAA800000, 32'h00FFFFFF, 32'h12000010};

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", {31'b0, out_valid}, 32'd0);
      check("R1", {31'b0, cfg_err}, 32'd0);
      check("R1", {31'b0, in_ready}, 32'd1);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      // R1: defaults are transparent
      foreach (pats[i]) begin
         send(pats[i], 1'b0, "R1");
         send(pats[i], 1'b1, "R1");
      end

      // R3, R4, R5: every legal shift in both directions
      foreach (shs[s]) begin
         cfg_write(3'd0, shs[s]);
         for (int rd = 0; rd < 2; rd++) begin
            foreach (pats[i]) send(pats[i], bit'(rd), (i == 0) ? "R5" : ((rd == 1) ? "R4" : "R3"));
         end
      end

      // R6: illegal amounts refused, previous amount kept
      cfg_write(3'd0, 32'd8);
      foreach (bad[b]) cfg_write(3'd0, bad[b]);
      send(32'h00C3_00FF, 1'b0, "R6");
      send(32'h00C3_00FF, 1'b1, "R6");
      cfg_write(3'd1, 32'd1);
      cfg_write(3'd4, 32'h0);
      cfg_write(3'd1, 32'd0);

      // R7: expansion keyed on bit 0 after the shift
      cfg_write(3'd0, 32'd0);
      cfg_write(3'd2, 32'h11223344);
      cfg_write(3'd3, 32'hCAFEF00D);
      cfg_write(3'd1, 32'd1);
      foreach (xpats[i]) send(xpats[i], 1'b0, "R7");
      cfg_write(3'd0, 32'd4);
      send(32'h00000010, 1'b1, "R7");
      send(32'h0000000F, 1'b1, "R7");
      send(32'h00000001, 1'b0, "R7");

      // R8: expansion disabled passes the shifted pixel
      cfg_write(3'd1, 32'd0);
      foreach (xpats[i]) send(xpats[i], 1'b1, "R8");
      cfg_write(3'd0, 32'd0);
      foreach (xpats[i]) send(xpats[i], 1'b0, "R8");

      // R9: signed add on the low field, top byte kept
      foreach (ks[k]) begin
         cfg_write(3'd4, ks[k]);
         foreach (apx[i]) send(apx[i], 1'b0, "R9");
      end

      // R10: saturation at both ends
      cfg_write(3'd4, 32'h007FFFFF);
      send(32'h00000001, 1'b0, "R10");
      send(32'hAB7FFFFF, 1'b0, "R10");
      send(32'h00400000, 1'b0, "R10");
      cfg_write(3'd4, 32'hFF800000);
      send(32'h00800000, 1'b0, "R10");
      send(32'h55FFFFFF, 1'b0, "R10");
      send(32'h00C00000, 1'b0, "R10");

      // R2: shift, then expand, then add
      cfg_write(3'd0, 32'd4);
      cfg_write(3'd2, 32'h01000010);
      cfg_write(3'd3, 32'h02FFFFF0);
      cfg_write(3'd4, 32'h00000020);
      cfg_write(3'd1, 32'd1);
      send(32'h00000010, 1'b1, "R2");
      send(32'h00000001, 1'b1, "R2");
      send(32'h0000001F, 1'b1, "R2");
      send(32'h00000001, 1'b0, "R2");

      // R11: latency of three and full rate
      cfg_write(3'd1, 32'd0);
      cfg_write(3'd4, 32'd0);
      cfg_write(3'd0, 32'hFFFFFFF4);
      in_valid = 1'b1;
      in_data  = 32'h89ABCDEF;
      in_rd    = 1'b0;
      @(negedge clk);
      check("R11", {31'b0, in_ready}, 32'd1);
      exp_q.push_back(model(32'h89ABCDEF, 1'b0));
      tag_q.push_back("R11");
      n_in++;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      @(negedge clk);
      check("R11", {31'b0, out_valid}, 32'd0);
      @(negedge clk);
      check("R11", {31'b0, out_valid}, 32'd0);
      @(negedge clk);
      check("R11", {31'b0, out_valid}, 32'd1);
      @(posedge clk);
      #1;
      drain();
      in_stalls = 0;
      for (int i = 0; i < 24; i++) send(32'h01010101 * i, bit'(i & 1), "R11");
      check("R11", in_stalls, 32'd0);

      // R12: random backpressure, mixed directions
      cfg_write(3'd0, 32'd12);
      cfg_write(3'd4, 32'h00001000);
      stall_mode = 1'b1;
      for (int i = 0; i < 80; i++) send(32'h9E3779B9 * (i + 1), bit'((i >> 1) & 1), "R12");
      drain();
      stall_mode = 1'b0;
      repeat (4) @(posedge clk);
      #1;
      check("R12", n_out, n_in);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL R12 watchdog actual hung expected completion");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule